// File: doc/BRIEF.md
# Three-Stage Pipelined 16-bit Integer Core with A-Operand Bypass

The block is a small 16-bit integer core built as a three-stage pipeline: fetch, decode with operand read, and execute. Each clock it presents a byte address to an instruction memory and latches the returned 16-bit word. In the same clock it decodes the word latched one cycle earlier and executes the one latched two cycles earlier. The execute result drives a result bus, which is written into a 16-entry register file at the end of that cycle. The result bus is also brought out on ports, so the host can watch every writeback.

Only the A operand has a bypass. A single 2:1 multiplexer in front of the A operand register picks the result bus instead of register port A when the instruction in decode reads the register that the instruction in execute is writing. The B operand has no bypass and no stall. A B-side dependence on the immediately preceding instruction therefore reads the older register contents, and software is expected to schedule around this.

Instruction word: bits [15:12] opcode, [11:8] destination, [7:4] source A, [3:0] source B or a 4-bit immediate. Opcodes: 0 no-op, 1 add, 2 subtract, 3 and, 4 or, 5 xor, 6 add-immediate (immediate sign-extended), 7 and-immediate (immediate zero-extended). Codes 8 to 15 behave as no-ops.

Top module: `pipe16_core`

## Requirements
- R1: While reset is high, and in the first two cycles after it is released, `imem_addr` is 0 at the first fetch and `res_valid` stays low. Registers read as zero after reset.
- R2: `imem_addr` starts at 0 after reset and rises by 2 on every clock edge.
- R3: One instruction enters per cycle. The result of the instruction at address 2*i appears on `res_valid`/`res_dst`/`res_data` during the cycle after the (i+2)-th clock edge following reset release, and is written to the register file at the end of that cycle.
- R4: Register forms compute 16-bit wrap-around add (1), subtract A-B (2), and (3), or (4) and xor (5).
- R5: Add-immediate (6) sign-extends the 4-bit field (values 8 to 15 mean -8 to -1). And-immediate (7) zero-extends it.
- R6: When the A source of the instruction in decode equals the destination of a writing instruction in execute, the A operand takes the just-computed result.
- R7: The B operand is never bypassed. A B source equal to the preceding instruction's destination yields that register's value from before the preceding instruction.
- R8: An instruction that writes no register (opcode 0, codes 8 to 15, or destination r0) triggers no forwarding and raises no `res_valid`.
- R9: Register r0 always reads as zero, and writes aimed at it are discarded.
- R10: A dependence two instructions apart reads the correct value from the register file, with no forwarding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 16 | Byte address of the instruction being fetched |
| imem_data | input | 16 | Instruction word at `imem_addr`, valid in the same cycle |
| res_valid | output | 1 | Execute-stage instruction writes a register this cycle |
| res_dst | output | 4 | Destination register of that write |
| res_data | output | 16 | Result bus value |

## Verification
The assertions assume that `imem_data` is a settled, known word whenever `imem_addr` is stable. They also assume that reset is held from time zero for at least one edge. The bench meets these by modelling the instruction memory as a combinational lookup of a preloaded array, filled with no-ops past the program, and by asserting reset before the first clock. Undefined opcodes are placed in the program on purpose, so the no-op handling is exercised while the instruction stream stays known.

// File: rtl/core_pkg.sv
package core_pkg;
    localparam int DW      = 16;
    localparam int RAW     = 4;
    localparam int NREG    = 1 << RAW;
    localparam int OPW     = 4;
    localparam int IMMW    = 4;
    localparam int PC_STEP = DW / 8;

    typedef enum logic [2:0] {
        FN_ADD = 3'd0,
        FN_SUB = 3'd1,
        FN_AND = 3'd2,
        FN_OR  = 3'd3,
        FN_XOR = 3'd4
    } alu_fn_e;

    typedef struct packed {
        alu_fn_e          fn;
        logic             wr;
        logic [RAW-1:0]   dst;
        logic [RAW-1:0]   src_a;
        logic [RAW-1:0]   src_b;
        logic             use_imm;
        logic [DW-1:0]    imm;
    } dec_t;

    typedef struct packed {
        alu_fn_e          fn;
        logic             wr;
        logic [RAW-1:0]   dst;
    } ex_ctrl_t;

    localparam logic [DW-1:0] NOP_WORD = '0;

    function automatic dec_t decode_word(input logic [DW-1:0] w);
        dec_t d;
        logic [OPW-1:0]  op;
        logic [IMMW-1:0] fld;
        op        = w[DW-1 -: OPW];
        fld       = w[IMMW-1:0];
        d.dst     = w[DW-OPW-1 -: RAW];
        d.src_a   = w[DW-OPW-RAW-1 -: RAW];
        d.src_b   = w[RAW-1:0];
        d.fn      = FN_ADD;
        d.wr      = 1'b1;
        d.use_imm = 1'b0;
        d.imm     = '0;
        case (op)
            4'd1: d.fn = FN_ADD;
            4'd2: d.fn = FN_SUB;
            4'd3: d.fn = FN_AND;
            4'd4: d.fn = FN_OR;
            4'd5: d.fn = FN_XOR;
            4'd6: begin
                d.fn      = FN_ADD;
                d.use_imm = 1'b1;
                d.imm     = {{(DW-IMMW){fld[IMMW-1]}}, fld};
            end
            4'd7: begin
                d.fn      = FN_AND;
                d.use_imm = 1'b1;
                d.imm     = {{(DW-IMMW){1'b0}}, fld};
            end
            default: d.wr = 1'b0;
        endcase
        if (d.dst == '0) d.wr = 1'b0;
        return d;
    endfunction

    function automatic logic [DW-1:0] alu_eval(input alu_fn_e fn,
                                               input logic [DW-1:0] a,
                                               input logic [DW-1:0] b);
        case (fn)
            FN_ADD:  return a + b;
            FN_SUB:  return a - b;
            FN_AND:  return a & b;
            FN_OR:   return a | b;
            FN_XOR:  return a ^ b;
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/pipe_fetch.sv
module pipe_fetch
    import core_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] mem_word,
    output logic [DW-1:0] pc,
    output logic [DW-1:0] ir
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
            ir <= NOP_WORD;
        end else begin
            pc <= pc + DW'(PC_STEP);
            ir <= mem_word;
        end
    end

    a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (pc == $past(pc) + DW'(PC_STEP)));
endmodule

// File: rtl/pipe_regfile.sv
module pipe_regfile
    import core_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [RAW-1:0] ra_addr,
    input  logic [RAW-1:0] rb_addr,
    output logic [DW-1:0]  ra_data,
    output logic [DW-1:0]  rb_data,
    input  logic           wr_en,
    input  logic [RAW-1:0] wr_addr,
    input  logic [DW-1:0]  wr_data
);
    logic [DW-1:0] regs [NREG];

    assign regs[0] = '0;

    for (genvar g = 1; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (wr_en && wr_addr == RAW'(g))
                regs[g] <= wr_data;
        end
    end

    assign ra_data = regs[ra_addr];
    assign rb_data = regs[rb_addr];
endmodule

// File: rtl/pipe_decode.sv
module pipe_decode
    import core_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [DW-1:0]  ir,
    output logic [RAW-1:0] rf_a_addr,
    output logic [RAW-1:0] rf_b_addr,
    input  logic [DW-1:0]  rf_a_data,
    input  logic [DW-1:0]  rf_b_data,
    input  logic           ex_wr,
    input  logic [RAW-1:0] ex_dst,
    input  logic [DW-1:0]  res_bus,
    output logic [DW-1:0]  op_a,
    output logic [DW-1:0]  op_b,
    output ex_ctrl_t       ex_ctrl
);
    dec_t          dec;
    logic          fwd_sel;
    logic [DW-1:0] a_next;
    logic [DW-1:0] b_next;

    always_comb begin
        dec       = decode_word(ir);
        rf_a_addr = dec.src_a;
        rf_b_addr = dec.src_b;
        fwd_sel   = ex_wr && (ex_dst == dec.src_a);
        a_next    = fwd_sel ? res_bus : rf_a_data;
        b_next    = dec.use_imm ? dec.imm : rf_b_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op_a    <= '0;
            op_b    <= '0;
            ex_ctrl <= '{fn: FN_ADD, wr: 1'b0, dst: '0};
        end else begin
            op_a    <= a_next;
            op_b    <= b_next;
            ex_ctrl <= '{fn: dec.fn, wr: dec.wr, dst: dec.dst};
        end
    end

    // R6: a forwarded operand equals the result bus of the previous cycle
    a_r6_fwd_value: assert property (@(posedge clk) disable iff (rst)
        fwd_sel |=> (op_a == $past(res_bus)));

    // R8: no bypass from an execute slot that does not write
    a_r8_no_fwd_idle: assert property (@(posedge clk) disable iff (rst)
        !ex_wr |-> !fwd_sel);
endmodule

// File: rtl/pipe_execute.sv
module pipe_execute
    import core_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  ex_ctrl_t      ctrl,
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    output logic [DW-1:0] result
);
    assign result = alu_eval(ctrl.fn, op_a, op_b);

    // R9: a write is never aimed at r0
    a_r9_no_r0_write: assert property (@(posedge clk) disable iff (rst)
        ctrl.wr |-> (ctrl.dst != '0));
endmodule

// File: rtl/pipe16_core.sv
module pipe16_core
    import core_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    output logic [15:0] imem_addr,
    input  logic [15:0] imem_data,
    output logic        res_valid,
    output logic [3:0]  res_dst,
    output logic [15:0] res_data
);
    logic [DW-1:0]  pc;
    logic [DW-1:0]  ir;
    logic [RAW-1:0] rf_a_addr;
    logic [RAW-1:0] rf_b_addr;
    logic [DW-1:0]  rf_a_data;
    logic [DW-1:0]  rf_b_data;
    logic [DW-1:0]  op_a;
    logic [DW-1:0]  op_b;
    ex_ctrl_t       ex_ctrl;
    logic [DW-1:0]  res_bus;

    pipe_fetch u_fetch (
        .clk      (clk),
        .rst      (rst),
        .mem_word (imem_data),
        .pc       (pc),
        .ir       (ir)
    );

    pipe_regfile u_rf (
        .clk     (clk),
        .rst     (rst),
        .ra_addr (rf_a_addr),
        .rb_addr (rf_b_addr),
        .ra_data (rf_a_data),
        .rb_data (rf_b_data),
        .wr_en   (ex_ctrl.wr),
        .wr_addr (ex_ctrl.dst),
        .wr_data (res_bus)
    );

    pipe_decode u_dec (
        .clk       (clk),
        .rst       (rst),
        .ir        (ir),
        .rf_a_addr (rf_a_addr),
        .rf_b_addr (rf_b_addr),
        .rf_a_data (rf_a_data),
        .rf_b_data (rf_b_data),
        .ex_wr     (ex_ctrl.wr),
        .ex_dst    (ex_ctrl.dst),
        .res_bus   (res_bus),
        .op_a      (op_a),
        .op_b      (op_b),
        .ex_ctrl   (ex_ctrl)
    );

    pipe_execute u_ex (
        .clk    (clk),
        .rst    (rst),
        .ctrl   (ex_ctrl),
        .op_a   (op_a),
        .op_b   (op_b),
        .result (res_bus)
    );

    assign imem_addr = pc;
    assign res_valid = ex_ctrl.wr;
    assign res_dst   = ex_ctrl.dst;
    assign res_data  = res_bus;

    // R1: the first execute slot after reset is a bubble
    a_r1_bubble_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !res_valid);
endmodule

// File: tb/test_pipe16_core.sv
module test_pipe16_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] imem_addr;
    logic [15:0] imem_data;
    logic        res_valid;
    logic [3:0]  res_dst;
    logic [15:0] res_data;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    localparam int NV = 20;
    localparam int MW = 32;

    // instruction word, then expected {valid, dst, data} in the execute slot
    localparam logic [15:0] PROG [NV] = '{
        16'h6106, 16'h6115, 16'h620F, 16'h732F, 16'h1413,
        16'h1531, 16'h2652, 16'h5765, 16'h4847, 16'h0000,
        16'h1988, 16'h6003, 16'h6A01, 16'h2BAA, 16'h6C08,
        16'hFD00, 16'h6ED1, 16'h3F2C, 16'h0000, 16'h0000
    };
    localparam logic [20:0] EXPV [NV] = '{
        {1'b1, 4'd1,  16'h0006},  // addi sign +6
        {1'b1, 4'd1,  16'h000B},  // A bypass
        {1'b1, 4'd2,  16'hFFFF},  // addi -1
        {1'b1, 4'd3,  16'h000F},  // andi zero-ext + A bypass
        {1'b1, 4'd4,  16'h000B},  // B stale
        {1'b1, 4'd5,  16'h001A},  // two apart
        {1'b1, 4'd6,  16'h001B},  // sub with bypass
        {1'b1, 4'd7,  16'h0001},  // xor
        {1'b1, 4'd8,  16'h000B},  // or, B stale
        {1'b0, 4'd0,  16'h0000},  // nop
        {1'b1, 4'd9,  16'h0016},  // add across nop
        {1'b0, 4'd0,  16'h0000},  // write to r0 dropped
        {1'b1, 4'd10, 16'h0001},  // no bypass from r0 writer
        {1'b1, 4'd11, 16'h0001},  // A bypass, B stale
        {1'b1, 4'd12, 16'hFFF8},  // addi -8
        {1'b0, 4'd0,  16'h0000},  // undefined opcode
        {1'b1, 4'd14, 16'h0001},  // no bypass from undefined
        {1'b1, 4'd15, 16'hFFF8},  // and register form
        {1'b0, 4'd0,  16'h0000},
        {1'b0, 4'd0,  16'h0000}
    };

    function automatic string tag_of(input int i);
        case (i)
            0, 2, 14:  return "R5";
            1, 3, 6:   return "R6";
            4, 8, 13:  return "R7";
            5, 10:     return "R10";
            7, 17:     return "R4";
            11:        return "R9";
            9, 12, 15, 16: return "R8";
            default:   return "R3";
        endcase
    endfunction

    logic [15:0] mem [MW];
    assign imem_data = mem[imem_addr[5:1]];

    pipe16_core i_pipe16_core (
        .clk       (clk),
        .rst       (rst),
        .imem_addr (imem_addr),
        .imem_data (imem_data),
        .res_valid (res_valid),
        .res_dst   (res_dst),
        .res_data  (res_data)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_slot(input int i);
        logic [20:0] e;
        e = EXPV[i];
        check(res_valid == e[20], {tag_of(i), " valid"}, 32'(res_valid), 32'(e[20]));
        if (e[20]) begin
            check(res_dst == e[19:16], {tag_of(i), " dst"}, 32'(res_dst), 32'(e[19:16]));
            check(res_data == e[15:0], {tag_of(i), " data"}, 32'(res_data), 32'(e[15:0]));
        end
    endtask

    initial begin
        for (int k = 0; k < MW; k++) mem[k] = (k < NV) ? PROG[k] : 16'h0000;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(imem_addr == 16'h0000, "R1 addr in reset", 32'(imem_addr), 32'h0);
        check(res_valid == 1'b0, "R1 valid in reset", 32'(res_valid), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check(res_valid == 1'b0, "R1 first slot", 32'(res_valid), 32'h0);
        @(negedge clk);
        // R3: one instruction per slot, two cycles after fetch
        for (int i = 0; i < NV; i++) begin
            check(imem_addr == 16'(2 * (i + 2)), "R2 pc step",
                  32'(imem_addr), 32'(2 * (i + 2)));
            check_slot(i);
            @(negedge clk);
        end
        // R1: reset in mid-run clears pc, bubbles and registers
        rst = 1'b1;
        @(negedge clk);
        check(imem_addr == 16'h0000, "R1 addr after reset", 32'(imem_addr), 32'h0);
        check(res_valid == 1'b0, "R1 valid after reset", 32'(res_valid), 32'h0);
        mem[0] = 16'h1110;  // add r1,r1,r0: r1 must read zero again
        mem[1] = 16'h6207;  // addi r2,r0,7
        mem[2] = 16'h1322;  // add r3,r2,r2: A bypass 7, B stale 0
        rst = 1'b0;
        @(negedge clk);
        check(res_valid == 1'b0, "R1 bubble after rerun", 32'(res_valid), 32'h0);
        @(negedge clk);
        check(res_valid && res_dst == 4'd1 && res_data == 16'h0000,
              "R1 registers cleared", {11'd0, res_valid, res_dst, res_data}, {11'd0, 1'b1, 4'd1, 16'h0});
        @(negedge clk);
        check(res_data == 16'h0007, "R5 rerun addi", 32'(res_data), 32'h7);
        @(negedge clk);
        check(res_data == 16'h0007, "R7 rerun stale B", 32'(res_data), 32'h7);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule